// File: doc/BRIEF.md
# Type II Digital Angle Tracking Loop

This block turns a stream of demodulated resolver samples into a shaft angle. Each sample is a signed pair holding the sine and the cosine of the shaft angle. The block keeps a 14-bit angle counter and forms the tracking error sin(theta)·cos(phi) − cos(theta)·sin(phi) from the sample pair and its own counter value phi. The error feeds a proportional-plus-integral filter. The integral part is the velocity word. The filter output is a signed rate that drives a phase accumulator. Each carry out of the accumulator moves the counter up one LSB, and each borrow moves it down one LSB.

The loop has two integrations: the velocity integrator and the counter. It therefore follows a constant-velocity input with no steady-state lag. The proportional path places the stabilising zero. The sine and cosine of phi come from a short quarter-wave table, with linear interpolation between its entries. The angle is natural binary: 1 LSB is 360/16384 degrees, and the counter wraps modulo 2^14 in both directions. The error output is scaled to angle LSBs, so a fault comparator can use it directly.

Top module: `angle_track_loop`

## Requirements
- R1: A synchronous active-high reset clears the angle, the error output, the velocity word and the accumulator phase. All three outputs read 0 on the first clock edge at which reset is high.
- R2: The angle output changes by at most one LSB per clock. The step is +1, −1 or 0, modulo 2^14.
- R3: With a constant input angle in any quadrant, the angle output settles to within ±3 LSB of the input angle.
- R4: The error output is a signed value in angle LSBs and is positive when the input angle leads the counter. A step of ±40 LSB in the input reads back as an error of about ±39 (within ±5) one clock edge after the strobed sample.
- R5: When the sample strobe is low, the error output and the velocity word hold their values, whatever the sample inputs carry.
- R6: A constant-velocity input is tracked with no steady lag. The angle stays within ±3 LSB of the input, and the velocity word equals the rate in units of 2^-16 LSB per clock (within ±800).
- R7: The velocity word and the accumulator rate are both limited to ±VEL_MAX (default 65536, that is, one LSB per clock). Under an input that moves faster than this limit, the velocity word reads exactly VEL_MAX and the angle advances exactly one LSB every clock.
- R8: The counter wraps cleanly in both directions, upward from 16383 to 0 and downward from 0 to 16383.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Strobe marking a valid sample pair |
| smp_sin | input | SMP_W | Signed sine sample of the shaft angle |
| smp_cos | input | SMP_W | Signed cosine sample of the shaft angle |
| angle | output | ANG_W | Tracked angle, natural binary |
| err_lsb | output | ERR_W | Signed tracking error in angle LSBs |
| velocity | output | PH_W+2 | Signed velocity word, 2^-PH_W LSB per clock |

## Verification
The error register captures on the clock edge that samples a strobed pair, so the bench reads the error at the falling edge that follows. The velocity word moves one edge later, and the angle moves at most once per edge. For this reason the hold test waits a few clocks after dropping the strobe before it records reference values. Settling takes thousands of cycles. The bench therefore waits a fixed count that is well above the worst slew time (one LSB per clock across the jump) before it compares the angle against the input angle. In the overspeed window it counts angle steps over an exact number of clocks. All outputs are sampled on the falling edge, after the rising-edge registers have settled.

// File: rtl/atl_pkg.sv
package atl_pkg;

    typedef enum logic [1:0] {
        QD_0   = 2'd0,
        QD_90  = 2'd1,
        QD_180 = 2'd2,
        QD_270 = 2'd3
    } quad_e;

    typedef struct packed {
        logic up;
        logic dn;
    } step_t;

    localparam real PI_R = 3.14159265358979;

    // One entry of a quarter-wave sine table with nseg segments, rounded.
    function automatic int quarter_sine(input int idx, input int nseg, input int amp);
        real a;
        a = PI_R * real'(idx) / (2.0 * real'(nseg));
        return $rtoi($sin(a) * real'(amp) + 0.5);
    endfunction

    // Fixed-point gain that turns a unit-amplitude sine product into turns/(2*pi).
    function automatic int err_gain(input int frac);
        return $rtoi((2.0 ** frac) / (2.0 * PI_R) + 0.5);
    endfunction

endpackage

// File: rtl/atl_trig.sv
module atl_trig
    import atl_pkg::*;
#(
    parameter int ANG_W    = 14,
    parameter int TRIG_W   = 16,
    parameter int SEG_BITS = 6
) (
    input  logic [ANG_W-1:0]         phi,
    output logic signed [TRIG_W-1:0] sin_o,
    output logic signed [TRIG_W-1:0] cos_o
);
    localparam int QW     = ANG_W - 2;
    localparam int FRAC_W = QW - SEG_BITS;
    localparam int NSEG   = 1 << SEG_BITS;
    localparam int AMP    = (1 << (TRIG_W - 1)) - 1;
    localparam int IW     = SEG_BITS + 1;
    localparam int DW     = TRIG_W + FRAC_W + 2;

    // Quarter-wave table; the last entry repeats full scale so interpolation never overruns.
    logic signed [TRIG_W-1:0] tbl [0:NSEG+1];

    generate
        for (genvar g = 0; g <= NSEG + 1; g++) begin : g_tbl
            localparam int ENTRY = quarter_sine((g > NSEG) ? NSEG : g, NSEG, AMP);
            assign tbl[g] = TRIG_W'(ENTRY);
        end
    endgenerate

    function automatic logic signed [TRIG_W-1:0] interp(input logic [QW:0] u);
        logic [IW-1:0]      ix;
        logic [IW-1:0]      ixn;
        logic [FRAC_W-1:0]  fr;
        logic signed [DW-1:0] d;
        ix  = u[QW:FRAC_W];
        ixn = ix + IW'(1);
        fr  = u[FRAC_W-1:0];
        d   = (DW'(tbl[ixn]) - DW'(tbl[ix])) * DW'($signed({1'b0, fr}));
        return tbl[ix] + TRIG_W'(d >>> FRAC_W);
    endfunction

    quad_e                    quad;
    logic [QW:0]              off;
    logic signed [TRIG_W-1:0] s_q;
    logic signed [TRIG_W-1:0] c_q;

    always_comb begin
        quad = quad_e'(phi[ANG_W-1:ANG_W-2]);
        off  = {1'b0, phi[QW-1:0]};
        s_q  = interp(off);
        c_q  = interp((QW + 1)'(1 << QW) - off);
        unique case (quad)
            QD_0:    begin sin_o =  s_q; cos_o =  c_q; end
            QD_90:   begin sin_o =  c_q; cos_o = -s_q; end
            QD_180:  begin sin_o = -s_q; cos_o = -c_q; end
            default: begin sin_o = -c_q; cos_o =  s_q; end
        endcase
    end

endmodule

// File: rtl/atl_phase_err.sv
module atl_phase_err
    import atl_pkg::*;
#(
    parameter int SMP_W    = 16,
    parameter int TRIG_W   = 16,
    parameter int ANG_W    = 14,
    parameter int ERR_W    = 16,
    parameter int ERR_FRAC = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     stb,
    input  logic signed [SMP_W-1:0]  smp_sin,
    input  logic signed [SMP_W-1:0]  smp_cos,
    input  logic signed [TRIG_W-1:0] sin_phi,
    input  logic signed [TRIG_W-1:0] cos_phi,
    output logic signed [ERR_W-1:0]  err_q,
    output logic                     err_vld
);
    localparam int PW  = SMP_W + TRIG_W + 1;
    localparam int SCW = PW + ERR_FRAC + 1;
    localparam int KG  = err_gain(ERR_FRAC);
    localparam int SH  = SMP_W + TRIG_W - 2 - ANG_W + ERR_FRAC;
    localparam logic signed [SCW-1:0] KS     = SCW'(KG);
    localparam logic signed [SCW-1:0] ERR_HI = SCW'((1 << (ERR_W - 1)) - 1);
    localparam logic signed [SCW-1:0] ERR_LO = -ERR_HI;

    logic signed [PW-1:0]    prod;
    logic signed [SCW-1:0]   scaled;
    logic signed [SCW-1:0]   shifted;
    logic signed [ERR_W-1:0] err_sat;

    // sin(theta)cos(phi) - cos(theta)sin(phi), then scaled to angle LSBs
    always_comb begin
        prod    = PW'(smp_sin) * PW'(cos_phi) - PW'(smp_cos) * PW'(sin_phi);
        scaled  = SCW'(prod) * KS;
        shifted = scaled >>> SH;
        if (shifted > ERR_HI)      err_sat = ERR_W'(ERR_HI);
        else if (shifted < ERR_LO) err_sat = ERR_W'(ERR_LO);
        else                       err_sat = ERR_W'(shifted);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q   <= '0;
            err_vld <= 1'b0;
        end else begin
            err_vld <= stb;
            if (stb) err_q <= err_sat;
        end
    end

    // R5: without a strobe the error register keeps its value
    assert_err_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !stb |=> $stable(err_q));

endmodule

// File: rtl/atl_loop_filter.sv
module atl_loop_filter #(
    parameter int ERR_W   = 16,
    parameter int VEL_W   = 18,
    parameter int KP_SH   = 12,
    parameter int KI_SH   = 6,
    parameter int VEL_MAX = 65536
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    err_vld,
    input  logic signed [ERR_W-1:0] err,
    output logic signed [VEL_W-1:0] vel_q,
    output logic signed [VEL_W-1:0] rate
);
    localparam int SW = ERR_W + KP_SH + KI_SH + VEL_W;
    localparam logic signed [SW-1:0] VHI = SW'(VEL_MAX);
    localparam logic signed [SW-1:0] VLO = -VHI;

    function automatic logic signed [VEL_W-1:0] clampv(input logic signed [SW-1:0] x);
        if (x > VHI)      return VEL_W'(VHI);
        else if (x < VLO) return VEL_W'(VLO);
        else              return VEL_W'(x);
    endfunction

    logic signed [SW-1:0] integ_sum;
    logic signed [SW-1:0] rate_sum;

    always_comb begin
        integ_sum = SW'(vel_q) + (SW'(err) <<< KI_SH);
        rate_sum  = SW'(vel_q) + (SW'(err) <<< KP_SH);
    end

    always_ff @(posedge clk) begin
        if (rst)          vel_q <= '0;
        else if (err_vld) vel_q <= clampv(integ_sum);
    end

    // Proportional path gives the lead zero; integral path is the velocity word
    assign rate = clampv(rate_sum);

    assert_vel_limit_R7: assert property (@(posedge clk) disable iff (rst)
        (SW'(vel_q) <= VHI) && (SW'(vel_q) >= VLO));

    assert_rate_limit_R7: assert property (@(posedge clk) disable iff (rst)
        (SW'(rate) <= VHI) && (SW'(rate) >= VLO));

    assert_vel_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !err_vld |=> $stable(vel_q));

endmodule

// File: rtl/atl_nco_counter.sv
module atl_nco_counter
    import atl_pkg::*;
#(
    parameter int ANG_W = 14,
    parameter int PH_W  = 16,
    parameter int VEL_W = 18
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [VEL_W-1:0] rate,
    output logic [ANG_W-1:0]        phi
);
    localparam int SUMW = VEL_W + 1;
    localparam logic signed [SUMW-1:0] WRAP = SUMW'(1 << PH_W);

    logic [PH_W-1:0]        phase_q;
    logic [ANG_W-1:0]       phi_q;
    logic signed [SUMW-1:0] sum;
    step_t                  st;

    always_comb begin
        sum   = SUMW'($signed({1'b0, phase_q})) + SUMW'(rate);
        st.up = (sum >= WRAP);
        st.dn = sum[SUMW-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            phi_q   <= '0;
        end else begin
            phase_q <= sum[PH_W-1:0];
            if (st.up)      phi_q <= phi_q + ANG_W'(1);
            else if (st.dn) phi_q <= phi_q - ANG_W'(1);
        end
    end

    assign phi = phi_q;

    // R2: counter moves by at most one LSB per clock, wrapping modulo 2^ANG_W
    assert_one_step_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (phi_q == $past(phi_q)) ||
                        (phi_q == $past(phi_q) + ANG_W'(1)) ||
                        (phi_q == $past(phi_q) - ANG_W'(1)));

endmodule

// File: rtl/angle_track_loop.sv
module angle_track_loop
    import atl_pkg::*;
#(
    parameter int ANG_W    = 14,
    parameter int SMP_W    = 16,
    parameter int TRIG_W   = 16,
    parameter int SEG_BITS = 6,
    parameter int ERR_W    = 16,
    parameter int ERR_FRAC = 16,
    parameter int PH_W     = 16,
    parameter int KP_SH    = 12,
    parameter int KI_SH    = 6,
    parameter int VEL_MAX  = 1 << 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     smp_vld,
    input  logic signed [SMP_W-1:0]  smp_sin,
    input  logic signed [SMP_W-1:0]  smp_cos,
    output logic [ANG_W-1:0]         angle,
    output logic signed [ERR_W-1:0]  err_lsb,
    output logic signed [PH_W+1:0]   velocity
);
    localparam int VEL_W = PH_W + 2;

    logic signed [TRIG_W-1:0] sin_phi;
    logic signed [TRIG_W-1:0] cos_phi;
    logic signed [ERR_W-1:0]  err_q;
    logic                     err_vld;
    logic signed [VEL_W-1:0]  vel_q;
    logic signed [VEL_W-1:0]  rate;
    logic [ANG_W-1:0]         phi;

    atl_trig #(
        .ANG_W(ANG_W), .TRIG_W(TRIG_W), .SEG_BITS(SEG_BITS)
    ) u_trig (
        .phi(phi), .sin_o(sin_phi), .cos_o(cos_phi)
    );

    atl_phase_err #(
        .SMP_W(SMP_W), .TRIG_W(TRIG_W), .ANG_W(ANG_W), .ERR_W(ERR_W), .ERR_FRAC(ERR_FRAC)
    ) u_err (
        .clk(clk), .rst(rst), .stb(smp_vld),
        .smp_sin(smp_sin), .smp_cos(smp_cos),
        .sin_phi(sin_phi), .cos_phi(cos_phi),
        .err_q(err_q), .err_vld(err_vld)
    );

    atl_loop_filter #(
        .ERR_W(ERR_W), .VEL_W(VEL_W), .KP_SH(KP_SH), .KI_SH(KI_SH), .VEL_MAX(VEL_MAX)
    ) u_filt (
        .clk(clk), .rst(rst), .err_vld(err_vld), .err(err_q),
        .vel_q(vel_q), .rate(rate)
    );

    atl_nco_counter #(
        .ANG_W(ANG_W), .PH_W(PH_W), .VEL_W(VEL_W)
    ) u_nco (
        .clk(clk), .rst(rst), .rate(rate), .phi(phi)
    );

    assign angle    = phi;
    assign err_lsb  = err_q;
    assign velocity = vel_q;

    // R1: one edge of reset leaves all outputs at zero
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (angle == '0) && (err_lsb == '0) && (velocity == '0));

endmodule

// File: tb/test_angle_track_loop.sv
module test_angle_track_loop;
    localparam real PI2 = 6.28318530717959;
    localparam real AIN = 32000.0;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               smp_vld = 1'b0;
    logic signed [15:0] smp_sin = '0;
    logic signed [15:0] smp_cos = 16'sd32000;
    logic [13:0]        angle;
    logic signed [15:0] err_lsb;
    logic signed [17:0] velocity;

    int     n_run  = 0;
    int     n_fail = 0;
    longint th_fp  = 0;
    longint th_rate = 0;
    bit     stb_en = 1'b1;

    always #4 clk = ~clk;

    angle_track_loop i_angle_track_loop (
        .clk(clk), .rst(rst), .smp_vld(smp_vld),
        .smp_sin(smp_sin), .smp_cos(smp_cos),
        .angle(angle), .err_lsb(err_lsb), .velocity(velocity)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: at the falling edge advance the input angle and drive the sample pair
    task automatic tick();
        real a;
        @(negedge clk);
        th_fp = th_fp + th_rate;
        a = real'(th_fp) * PI2 / (16384.0 * 65536.0);
        smp_sin = 16'($rtoi(AIN * $sin(a) + (($sin(a) >= 0.0) ? 0.5 : -0.5)));
        smp_cos = 16'($rtoi(AIN * $cos(a) + (($cos(a) >= 0.0) ? 0.5 : -0.5)));
        smp_vld = stb_en;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    function automatic int wrapd(input int d);
        int m;
        m = d & 16383;
        return (m >= 8192) ? m - 16384 : m;
    endfunction

    function automatic int adiff();
        return wrapd(int'(angle) - int'(th_fp >>> 16));
    endfunction

    initial begin
        int d;
        int e0;
        int v0;
        int a0;
        // R1: reset state
        run(4);
        chk(angle == 0,    "R1 angle", int'(angle), 0);
        chk(err_lsb == 0,  "R1 error", int'(err_lsb), 0);
        chk(velocity == 0, "R1 velocity", int'(velocity), 0);
        rst = 1'b0;

        // R3: static targets sweeping all four quadrants
        for (int k = 0; k < 12; k++) begin
            th_fp = longint'(k * 1365 + 77) <<< 16;
            run(3000);
            d = adiff();
            chk(d >= -3 && d <= 3, "R3 static settle", d, 0);
        end

        // R4: error sign and scale for a step ahead and behind
        th_fp = th_fp + (longint'(40) <<< 16);
        tick();
        tick();
        chk(err_lsb >= 34 && err_lsb <= 44, "R4 lead step error", int'(err_lsb), 39);
        run(1500);
        th_fp = th_fp - (longint'(40) <<< 16);
        tick();
        tick();
        chk(err_lsb >= -44 && err_lsb <= -34, "R4 lag step error", int'(err_lsb), -39);
        run(1500);

        // R5: with no strobe, error and velocity hold even when the samples change
        stb_en = 1'b0;
        run(4);
        e0 = int'(err_lsb);
        v0 = int'(velocity);
        th_fp = th_fp + (longint'(500) <<< 16);
        run(50);
        chk(int'(err_lsb) == e0,  "R5 error hold", int'(err_lsb), e0);
        chk(int'(velocity) == v0, "R5 velocity hold", int'(velocity), v0);
        stb_en = 1'b1;
        run(2000);

        // R6: constant velocity of 1/16 LSB per clock, no lag
        th_rate = 4096;
        run(3000);
        d = adiff();
        chk(d >= -3 && d <= 3, "R6 ramp lag", d, 0);
        chk(velocity >= 3296 && velocity <= 4896, "R6 velocity word", int'(velocity), 4096);

        // R8: downward ramp across zero
        th_rate = 0;
        th_fp = longint'(200) <<< 16;
        run(3000);
        th_rate = -4096;
        run(4800);
        d = adiff();
        chk(d >= -3 && d <= 3, "R8 down wrap track", d, 0);
        chk(angle >= 14'd16200, "R8 down wrap angle", int'(angle), 16284);

        // R7: overspeed input, rate limit gives one step every clock, upward wrap (R8)
        th_rate = 0;
        th_fp = longint'(14500) <<< 16;
        run(3000);
        th_rate = longint'(2) <<< 16;
        run(1500);
        a0 = int'(angle);
        run(400);
        chk(((int'(angle) - a0) & 16383) == 400, "R7 one step per clock", (int'(angle) - a0) & 16383, 400);
        chk(int'(angle) < a0, "R8 up wrap", int'(angle), a0 + 400 - 16384);
        chk(velocity == 18'sd65536, "R7 velocity limit", int'(velocity), 65536);

        // R1: reset in mid-run
        th_rate = 0;
        rst = 1'b1;
        tick();
        tick();
        chk(angle == 0 && err_lsb == 0 && velocity == 0, "R1 mid-run reset",
            int'(angle) + int'(err_lsb) + int'(velocity), 0);
        rst = 1'b0;
        run(4);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog R3 run hung actual=%0d expected=%0d", 150000, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule